// File: doc/BRIEF.md
# MSI-X Vector Table and Message Sender

This block sits on the endpoint side of a PCI Express function. It keeps a small MSI-X vector table inside the function's own memory-mapped register window, plus a pending-bit word. Host software programs each vector's message address, message data and mask bit through a simple 64-bit register bus that carries byte enables. One bus access may update a single byte or two adjacent dwords at once.

A request on one of the per-vector interrupt lines is recorded as pending. An unmasked pending vector is turned into an outbound request on the transaction-request interface. That request is an ordinary memory write of exactly one dword, with the entry's message address as its target and the entry's message data as its payload. The dedicated MSI sideband of the transport core is not used. Vectors that are masked individually, or by the function-wide mask, stay pending. Their write goes out once the mask is removed. When several vectors are eligible, one write is presented at a time, and the lowest-numbered vector goes first.

Top module: `msix_unit`

## Requirements
- R1: Vector v occupies 16 bytes starting at TABLE_OFS + 16*v. The message address low dword is at +0, the high dword at +4, the message data at +8, and the control word at +12, whose bit 0 is the mask. A read with bus_rd high returns the addressed data on bus_rdata, with bus_rvalid high, in the cycle after the request.
- R2: After reset every address and data word reads 0, every vector's mask bit reads 1, no bit is pending and tx_valid is low.
- R3: On a write, only the bytes whose bus_be bit is set change. bus_be[k] covers bus_wdata[8k+7:8k].
- R4: bus_addr[2] is ignored. bus_wdata[31:0] goes to the dword at bus_addr with bit 2 cleared, and bus_wdata[63:32] goes to the dword above it. A single access may therefore update two fields of an entry.
- R5: While func_mask is high, no write is started. Requests are kept as pending bits and are sent after func_mask falls.
- R6: A request on a vector whose mask bit is 1 sets bit v of the pending word at PBA_OFS and sends nothing. Clearing the mask bit causes the write to be sent and the pending bit to be cleared.
- R7: Each outbound request has tx_len equal to 1 (one dword). tx_addr is the entry's {high, low} address and tx_data is the entry's data.
- R8: tx_addr[1:0] is always 0. A message address with nonzero low bits is still sent, aligned down to the dword.
- R9: Several eligible vectors are sent one at a time, lowest number first.
- R10: While tx_valid is high and tx_ready is low, tx_valid, tx_addr and tx_data hold steady. A write is consumed on a clock edge where both are high.
- R11: Writes to the pending word or to unmapped addresses change nothing. Bits 31:1 of a control word read 0. Unmapped addresses read 0.
- R12: When irq_req[v] is high at edge k on an eligible vector and the request interface is idle, tx_valid is high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte address within the BAR |
| bus_wdata | input | 64 | Write data, two dword lanes |
| bus_be | input | 8 | Byte enables for bus_wdata |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| func_mask | input | 1 | Function-wide mask from configuration space |
| irq_req | input | NUM_VEC (8) | Per-vector interrupt request, one pulse per message |
| tx_valid | output | 1 | Outbound memory write request valid |
| tx_ready | input | 1 | Transport core accepts the request |
| tx_addr | output | 64 | Memory write address, dword aligned |
| tx_data | output | 32 | Memory write payload |
| tx_len | output | 10 | Payload length in dwords, always 1 |

## Verification
The bench uses the default parameters: eight vectors, the table at byte offset 0x100 and the pending word at 0x180 of a 4 KiB window. With these values, every field of the first four entries can be reached with whole, aggregated and single-byte writes, and a single pending word covers all vectors. Vectors 1 and 3 can then compete to test the lowest-first ordering. A masked vector (2) stays pending until software clears its mask.

// File: rtl/msix_pkg.sv
package msix_pkg;
    localparam int BUS_DW = 64;
    localparam int BUS_BE = BUS_DW / 8;
    localparam int LANES  = BUS_DW / 32;

    // Replace only the bytes whose enable is set.
    function automatic logic [31:0] be_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/msix_pick.sv
module msix_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/msix_table.sv
module msix_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC   = 8,
    parameter int ADDR_W    = 12,
    parameter int TABLE_OFS = 'h100,
    parameter int PBA_OFS   = 'h180,
    parameter int VW        = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    input  logic [BUS_BE-1:0]   bus_be,
    input  logic [NUM_VEC-1:0]  pend_in,
    input  logic [VW-1:0]       sel_idx,
    output logic [BUS_DW-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [NUM_VEC-1:0]  vec_mask,
    output logic [63:0]         sel_addr,
    output logic [31:0]         sel_data
);
    localparam int DA_W     = ADDR_W - 2;
    localparam int TBL_DW   = TABLE_OFS / 4;
    localparam int TBL_SPAN = NUM_VEC * 4;
    localparam int PBA_DW   = PBA_OFS / 4;

    typedef struct packed {
        logic [NUM_VEC-1:0][31:0] lo;
        logic [NUM_VEC-1:0][31:0] hi;
        logic [NUM_VEC-1:0][31:0] dat;
        logic [NUM_VEC-1:0]       msk;
        logic [BUS_DW-1:0]        rdata;
        logic                     rvalid;
    } tbl_t;

    tbl_t s_d, s_q;

    logic [LANES-1:0][DA_W-1:0] lane_dw;
    logic [LANES-1:0][DA_W-1:0] lane_rel;
    logic [LANES-1:0]           lane_hit;
    logic [LANES-1:0]           lane_pba;
    logic [LANES-1:0][VW-1:0]   lane_vi;
    logic [LANES-1:0][1:0]      lane_fld;

    // Per-lane dword decode: lane l targets dword {addr[..:3], l}.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_dw[l]  = {bus_addr[ADDR_W-1:3], 1'(l)};
        assign lane_rel[l] = lane_dw[l] - DA_W'(TBL_DW);
        assign lane_hit[l] = (lane_dw[l] >= DA_W'(TBL_DW)) &&
                             (lane_dw[l] <  DA_W'(TBL_DW + TBL_SPAN));
        assign lane_pba[l] = (lane_dw[l] == DA_W'(PBA_DW));
        assign lane_vi[l]  = lane_rel[l][VW+1:2];
        assign lane_fld[l] = lane_rel[l][1:0];
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = bus_rd;
        s_d.rdata  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (bus_wr && lane_hit[l]) begin
                case (lane_fld[l])
                    2'd0: s_d.lo[lane_vi[l]]  = be_merge(s_q.lo[lane_vi[l]],
                                                  bus_wdata[32*l +: 32], bus_be[4*l +: 4]);
                    2'd1: s_d.hi[lane_vi[l]]  = be_merge(s_q.hi[lane_vi[l]],
                                                  bus_wdata[32*l +: 32], bus_be[4*l +: 4]);
                    2'd2: s_d.dat[lane_vi[l]] = be_merge(s_q.dat[lane_vi[l]],
                                                  bus_wdata[32*l +: 32], bus_be[4*l +: 4]);
                    default: begin
                        if (bus_be[4*l]) s_d.msk[lane_vi[l]] = bus_wdata[32*l];
                    end
                endcase
            end
            if (bus_rd) begin
                if (lane_hit[l]) begin
                    case (lane_fld[l])
                        2'd0:    s_d.rdata[32*l +: 32] = s_q.lo[lane_vi[l]];
                        2'd1:    s_d.rdata[32*l +: 32] = s_q.hi[lane_vi[l]];
                        2'd2:    s_d.rdata[32*l +: 32] = s_q.dat[lane_vi[l]];
                        default: s_d.rdata[32*l +: 32] = {31'd0, s_q.msk[lane_vi[l]]};
                    endcase
                end else if (lane_pba[l]) begin
                    s_d.rdata[32*l +: 32] = 32'(pend_in);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.lo     <= '0;
            s_q.hi     <= '0;
            s_q.dat    <= '0;
            s_q.msk    <= '1;
            s_q.rdata  <= '0;
            s_q.rvalid <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata  = s_q.rdata;
    assign bus_rvalid = s_q.rvalid;
    assign vec_mask   = s_q.msk;
    assign sel_addr   = {s_q.hi[sel_idx], s_q.lo[sel_idx][31:2], 2'b00};
    assign sel_data   = s_q.dat[sel_idx];
endmodule

// File: rtl/msix_send.sv
module msix_send #(
    parameter int NUM_VEC = 8,
    parameter int VW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic [NUM_VEC-1:0] vec_mask,
    input  logic               func_mask,
    input  logic               tx_ready,
    input  logic [63:0]        sel_addr,
    input  logic [31:0]        sel_data,
    output logic [VW-1:0]      sel_idx,
    output logic [NUM_VEC-1:0] pend,
    output logic               tx_valid,
    output logic [63:0]        tx_addr,
    output logic [31:0]        tx_data
);
    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic               txv;
        logic [63:0]        addr;
        logic [31:0]        data;
    } snd_t;

    snd_t s_d, s_q;
    logic [NUM_VEC-1:0] elig;
    logic [NUM_VEC-1:0] clr;
    logic               found;

    assign elig = s_q.pend & ~vec_mask & {NUM_VEC{~func_mask}};

    msix_pick #(.N(NUM_VEC), .W(VW)) u_pick (
        .req   (elig),
        .found (found),
        .idx   (sel_idx)
    );

    always_comb begin
        s_d = s_q;
        clr = '0;
        if (s_q.txv && tx_ready) s_d.txv = 1'b0;
        if ((!s_q.txv || tx_ready) && found) begin
            s_d.txv  = 1'b1;
            s_d.addr = sel_addr;
            s_d.data = sel_data;
            clr[sel_idx] = 1'b1;
        end
        s_d.pend = (s_q.pend & ~clr) | irq_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend     = s_q.pend;
    assign tx_valid = s_q.txv;
    assign tx_addr  = s_q.addr;
    assign tx_data  = s_q.data;
endmodule

// File: rtl/msix_unit.sv
module msix_unit
    import msix_pkg::*;
#(
    parameter int NUM_VEC   = 8,
    parameter int ADDR_W    = 12,
    parameter int TABLE_OFS = 'h100,
    parameter int PBA_OFS   = 'h180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [63:0]        bus_wdata,
    input  logic [7:0]         bus_be,
    output logic [63:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic               func_mask,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [63:0]        tx_addr,
    output logic [31:0]        tx_data,
    output logic [9:0]         tx_len
);
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [NUM_VEC-1:0] vec_mask;
    logic [NUM_VEC-1:0] pend_vec;
    logic [VW-1:0]      sel_idx;
    logic [63:0]        sel_addr;
    logic [31:0]        sel_data;

    msix_table #(
        .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .TABLE_OFS(TABLE_OFS),
        .PBA_OFS(PBA_OFS), .VW(VW)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be),
        .pend_in(pend_vec), .sel_idx(sel_idx),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .vec_mask(vec_mask), .sel_addr(sel_addr), .sel_data(sel_data)
    );

    msix_send #(.NUM_VEC(NUM_VEC), .VW(VW)) u_send (
        .clk(clk), .rst_n(rst_n),
        .irq_req(irq_req), .vec_mask(vec_mask), .func_mask(func_mask),
        .tx_ready(tx_ready), .sel_addr(sel_addr), .sel_data(sel_data),
        .sel_idx(sel_idx), .pend(pend_vec),
        .tx_valid(tx_valid), .tx_addr(tx_addr), .tx_data(tx_data)
    );

    assign tx_len = 10'd1;
endmodule

// File: rtl/msix_unit_chk.sv
module msix_unit_chk #(
    parameter int NUM_VEC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               func_mask,
    input logic [NUM_VEC-1:0] irq_req,
    input logic [NUM_VEC-1:0] vec_mask,
    input logic [NUM_VEC-1:0] pend_vec,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [63:0]        tx_addr,
    input logic [31:0]        tx_data,
    input logic               bus_rd,
    input logic               bus_rvalid
);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr) && $stable(tx_data)));

    p_fmask_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && (!$past(tx_valid) || $past(tx_ready))) |-> !$past(func_mask));

    p_masked_pends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_req & vec_mask)) |=>
            ((pend_vec & $past(irq_req & vec_mask)) == $past(irq_req & vec_mask)));

    p_rd_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    p_rd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_addr[1:0] == 2'b00));
endmodule

bind msix_unit msix_unit_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .func_mask(func_mask), .irq_req(irq_req),
    .vec_mask(vec_mask), .pend_vec(pend_vec), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_data(tx_data),
    .bus_rd(bus_rd), .bus_rvalid(bus_rvalid)
);

// File: tb/msix_unit_test.sv
module msix_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [7:0]  bus_be = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic        func_mask = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [63:0] tx_addr;
    logic [31:0] tx_data;
    logic [9:0]  tx_len;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    msix_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .func_mask(func_mask),
        .irq_req(irq_req), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_addr(tx_addr), .tx_data(tx_data), .tx_len(tx_len)
    );

    typedef struct packed {
        logic [11:0] a;
        logic [63:0] d;
        logic [7:0]  be;
        logic [63:0] e;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{12'h100, 64'h00000001_FEE01003, 8'hFF, 64'h00000001_FEE01003}, // R4 lo+hi, vec0
        '{12'h108, 64'h00000000_0000A000, 8'hFF, 64'h00000000_0000A000}, // R4 data+ctrl
        '{12'h10C, 64'hFFFFFFFF_000055BB, 8'h01, 64'h00000000_0000A0BB}, // R3 byte 0 only
        '{12'h108, 64'hFFFFFFFE_00000000, 8'hF0, 64'h00000000_0000A0BB}, // R11 ctrl upper bits
        '{12'h110, 64'h00000000_FEE02000, 8'hFF, 64'h00000000_FEE02000}, // R1 vec1
        '{12'h118, 64'h00000000_0000B001, 8'hFF, 64'h00000000_0000B001},
        '{12'h120, 64'h00000000_FEE03000, 8'hFF, 64'h00000000_FEE03000}, // vec2
        '{12'h128, 64'h00000001_0000C002, 8'hFF, 64'h00000001_0000C002}, // vec2 masked
        '{12'h130, 64'h00000000_FEE04000, 8'hFF, 64'h00000000_FEE04000}, // vec3
        '{12'h138, 64'h00000000_0000D003, 8'hFF, 64'h00000000_0000D003},
        '{12'h180, 64'hFFFFFFFF_FFFFFFFF, 8'hFF, 64'h00000000_00000000}, // R11 pending word
        '{12'h000, 64'hFFFFFFFF_FFFFFFFF, 8'hFF, 64'h00000000_00000000}  // R11 unmapped
    };

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input string req, input logic [11:0] a, input logic [63:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check64({req, " rvalid"}, 64'(bus_rvalid), 64'd1);
        check64(req, bus_rdata, exp);
    endtask

    task automatic pulse_irq(input logic [7:0] v);
        @(negedge clk);
        irq_req = v;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic handshake();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check64("R2 tx_valid", 64'(tx_valid), 64'd0);
        bus_read("R2 vec0 addr", 12'h100, 64'd0);
        bus_read("R2 vec0 data/mask", 12'h108, 64'h00000001_00000000);
        bus_read("R2 vec7 data/mask", 12'h178, 64'h00000001_00000000);
        bus_read("R2 pending", 12'h180, 64'd0);

        // Table walk: write then read back (R1, R3, R4, R11)
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].a, VECS[i].d, VECS[i].be);
            bus_read("R1 table readback", VECS[i].a, VECS[i].e);
        end

        // R12 latency, R7 content, R8 alignment, R10 hold
        pulse_irq(8'h01);
        check64("R12 not yet valid", 64'(tx_valid), 64'd0);
        @(negedge clk);
        check64("R12 valid", 64'(tx_valid), 64'd1);
        check64("R8 aligned addr", tx_addr, 64'h00000001_FEE01000);
        check64("R7 data", 64'(tx_data), 64'h0000A0BB);
        check64("R7 len", 64'(tx_len), 64'd1);
        repeat (3) @(negedge clk);
        check64("R10 held valid", 64'(tx_valid), 64'd1);
        check64("R10 held addr", tx_addr, 64'h00000001_FEE01000);
        handshake();
        check64("R10 consumed", 64'(tx_valid), 64'd0);

        // R9 lowest first
        pulse_irq(8'h0A);
        @(negedge clk);
        check64("R9 first vec1", 64'(tx_data), 64'h0000B001);
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        check64("R9 second vec3 valid", 64'(tx_valid), 64'd1);
        check64("R9 second vec3", 64'(tx_data), 64'h0000D003);
        @(negedge clk);
        tx_ready = 1'b0;
        check64("R9 drained", 64'(tx_valid), 64'd0);

        // R6 per-vector mask
        pulse_irq(8'h04);
        repeat (3) @(negedge clk);
        check64("R6 masked no send", 64'(tx_valid), 64'd0);
        bus_read("R6 pending bit", 12'h180, 64'h4);
        bus_write(12'h128, 64'h0, 8'hF0);
        @(negedge clk);
        check64("R6 unmasked send", 64'(tx_valid), 64'd1);
        check64("R6 addr", tx_addr, 64'h00000000_FEE03000);
        check64("R6 data", 64'(tx_data), 64'h0000C002);
        handshake();
        bus_read("R6 pending cleared", 12'h180, 64'h0);

        // R5 function mask
        func_mask = 1'b1;
        pulse_irq(8'h02);
        repeat (3) @(negedge clk);
        check64("R5 blocked", 64'(tx_valid), 64'd0);
        bus_read("R5 pending", 12'h180, 64'h2);
        func_mask = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check64("R5 released", 64'(tx_valid), 64'd1);
        check64("R5 data", 64'(tx_data), 64'h0000B001);
        handshake();
        check64("R5 done", 64'(tx_valid), 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule